// File: doc/BRIEF.md
# Translation Lookaside Buffer with Global-Page Flush Control

This block is a small, fully associative cache of virtual-to-physical page translations. Each slot keeps the physical frame, the combined read/write/execute rights, the accessed and dirty flags, two caching-control flags, a global marker, a present marker and a page-size code. A lookup compares the virtual address with every slot, ignoring the address bits that fall inside the slot's page size. The result is available in the same cycle: a hit, a not-present fault, or a request to update the dirty flag.

An external page walker installs translations through the fill port. Software-visible invalidation reaches the block through a two-bit command port. One command removes any slot that covers a given address. A second clears every slot that is not global, which is the effect of switching address spaces. The third clears every slot, including global ones. A configuration input decides whether a walker may install not-present (negative) translations.

Commands and fills are applied on the clock edge. When both arrive in the same cycle, the invalidation is applied first and the fill is written afterwards. A fill goes into a slot already covering its address if there is one. Otherwise it goes into the lowest-numbered empty slot, and when no slot is empty a round-robin pointer picks the slot.

Top module: `tlb_cache`

## Requirements
- R1: A lookup (`lk_valid` high) gives its result in the same cycle. On a hit, `lk_pa` takes the frame bits above the page-size boundary and the virtual address bits below it.
- R2: Page-size codes are 0 = 4 KiB, 1 = 2 MiB, 2 = 4 MiB and 3 = 1 GiB. A slot covers an address when the virtual bits at and above its page-size boundary are equal.
- R3: On a hit or fault, the outputs show the slot's rights (bit 0 read, bit 1 write, bit 2 execute), its accessed flag, its dirty flag and its cache flags (bit 0 write-through, bit 1 cache-disable). On a miss they are all zero.
- R4: Command code 2 clears every slot whose global bit is clear. Global slots stay usable.
- R5: Command code 3 clears every slot, global or not.
- R6: Command code 1 clears every slot that covers `inv_vpn` under that slot's page size, global or not. Command code 0 does nothing.
- R7: With `neg_cache_en` high, a fill with `fill_present` low installs a slot, and lookups that hit it raise `lk_fault` instead of `lk_hit`. With `neg_cache_en` low, such a fill changes nothing.
- R8: A write lookup (`lk_write` high) that matches a present slot with a clear dirty flag raises `lk_upd` and not `lk_hit`. `lk_hit`, `lk_fault` and `lk_upd` are never high together.
- R9: A fill overwrites the first slot that already covers its address. Otherwise it takes the lowest-numbered empty slot. Otherwise it takes the slot named by a round-robin pointer, which starts at 0 and advances by one each time it is used.
- R10: When an invalidation and a fill happen in the same cycle, the invalidation is applied first and the fill is then written, so the filled translation remains.
- R11: After reset no slot is valid, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| neg_cache_en | input | 1 | Allow not-present translations to be cached |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | Usable translation found |
| lk_fault | output | 1 | Matching slot is not present |
| lk_upd | output | 1 | Write to a clean slot, walker must set dirty |
| lk_pa | output | 40 | Translated physical address |
| lk_perm | output | 3 | Rights of the matching slot |
| lk_acc | output | 1 | Accessed flag of the matching slot |
| lk_dirty | output | 1 | Dirty flag of the matching slot |
| lk_cache | output | 2 | Cache flags of the matching slot |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 28 | Physical frame number to install |
| fill_size | input | 2 | Page-size code |
| fill_global | input | 1 | Global marker |
| fill_present | input | 1 | Present marker |
| fill_perm | input | 3 | Rights |
| fill_acc | input | 1 | Accessed flag |
| fill_dirty | input | 1 | Dirty flag |
| fill_cache | input | 2 | Cache flags |
| inv_cmd | input | 2 | 0 none, 1 single page, 2 non-global, 3 all |
| inv_vpn | input | 20 | Virtual page number for a single-page command |

## Verification
Lookup results are combinational, so the bench drives each cycle's inputs just after the falling edge and compares every lookup output 2 ns later, in that same cycle. Fills and invalidations change the slots on the next rising edge, so their effect is checked through a lookup made in the following cycle. A behavioural model of the slots is updated on that same rising edge, so the model and the design always have the same number of edges behind them. Same-cycle invalidation with a fill, round-robin eviction after all sixteen slots are full, and negative caching with the enable both low and high are each driven as their own sequence.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 40;
    localparam int PG_SH = 12;
    localparam int VPN_W = VA_W - PG_SH;
    localparam int PPN_W = PA_W - PG_SH;

    typedef enum logic [1:0] {PS_4K = 2'd0, PS_2M = 2'd1, PS_4M = 2'd2, PS_1G = 2'd3} pg_size_e;
    typedef enum logic [1:0] {INV_NONE = 2'd0, INV_PAGE = 2'd1, INV_NONGLB = 2'd2, INV_ALL = 2'd3} inv_cmd_e;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        pg_size_e         size;
        logic             glob;
        logic             present;
        logic [2:0]       perm;
        logic             acc;
        logic             dirty;
        logic [1:0]       cache;
    } tlb_ent_t;

    // number of page-number bits that fall inside the page for this size
    function automatic int size_shift(pg_size_e s);
        case (s)
            PS_2M:   return 9;
            PS_4M:   return 10;
            PS_1G:   return 18;
            default: return 0;
        endcase
    endfunction

    function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
        return {VPN_W{1'b1}} << size_shift(s);
    endfunction

    function automatic logic [PA_W-1:0] off_mask(pg_size_e s);
        return ~({PA_W{1'b1}} << (PG_SH + size_shift(s)));
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  tlb_ent_t [N-1:0] ents,
    input  logic [VPN_W-1:0] vpn,
    output logic [N-1:0]     hit,
    output logic             any,
    output logic [IW-1:0]    first
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = ents[g].valid &&
                        (((ents[g].vpn ^ vpn) & vpn_mask(ents[g].size)) == '0);
    end

    assign any = |hit;

    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) first = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  same,
    input  logic [IW-1:0] rr,
    output logic [IW-1:0] idx,
    output logic          use_rr
);
    logic [IW-1:0] same_idx, free_idx;

    always_comb begin
        same_idx = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same[i])   same_idx = IW'(i);
            if (!valid[i]) free_idx = IW'(i);
        end
        use_rr = 1'b0;
        if (|same)           idx = same_idx;
        else if (!(&valid))  idx = free_idx;
        else begin
            idx    = rr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   neg_cache_en,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_va,
    input  logic                   lk_write,
    output logic                   lk_hit,
    output logic                   lk_fault,
    output logic                   lk_upd,
    output logic [PA_W-1:0]        lk_pa,
    output logic [2:0]             lk_perm,
    output logic                   lk_acc,
    output logic                   lk_dirty,
    output logic [1:0]             lk_cache,
    input  logic                   fill_valid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic [1:0]             fill_size,
    input  logic                   fill_global,
    input  logic                   fill_present,
    input  logic [2:0]             fill_perm,
    input  logic                   fill_acc,
    input  logic                   fill_dirty,
    input  logic [1:0]             fill_cache,
    input  logic [1:0]             inv_cmd,
    input  logic [VPN_W-1:0]       inv_vpn
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        tlb_ent_t [N-1:0] ent;
        logic [IW-1:0]    rr;
    } tlb_state_t;

    tlb_state_t       st_d, st_q;
    tlb_ent_t [N-1:0] ent_mid;
    logic [N-1:0]     lk_hitv, inv_hitv, fill_hitv, mid_valid, valid_q, glob_q;
    logic             lk_any, inv_any, fill_any;
    logic [IW-1:0]    lk_idx, inv_idx, fill_idx, vic_idx;
    logic             vic_rr;
    inv_cmd_e         cmd;
    tlb_ent_t         sel;
    logic [PA_W-1:0]  om;

    assign cmd = inv_cmd_e'(inv_cmd);

    tlb_match #(.N(N)) u_lk_match (
        .ents(st_q.ent), .vpn(lk_va[VA_W-1:PG_SH]),
        .hit(lk_hitv), .any(lk_any), .first(lk_idx));

    tlb_match #(.N(N)) u_inv_match (
        .ents(st_q.ent), .vpn(inv_vpn),
        .hit(inv_hitv), .any(inv_any), .first(inv_idx));

    // slots after this cycle's invalidation, before the fill
    always_comb begin
        ent_mid = st_q.ent;
        for (int i = 0; i < N; i++) begin
            case (cmd)
                INV_PAGE:   if (inv_hitv[i]) ent_mid[i].valid = 1'b0;
                INV_NONGLB: if (!st_q.ent[i].glob) ent_mid[i].valid = 1'b0;
                INV_ALL:    ent_mid[i].valid = 1'b0;
                default:    ;
            endcase
            mid_valid[i] = ent_mid[i].valid;
            valid_q[i]   = st_q.ent[i].valid;
            glob_q[i]    = st_q.ent[i].glob;
        end
    end

    tlb_match #(.N(N)) u_fill_match (
        .ents(ent_mid), .vpn(fill_vpn),
        .hit(fill_hitv), .any(fill_any), .first(fill_idx));

    tlb_victim #(.N(N)) u_victim (
        .valid(mid_valid), .same(fill_hitv), .rr(st_q.rr),
        .idx(vic_idx), .use_rr(vic_rr));

    always_comb begin
        st_d     = st_q;
        st_d.ent = ent_mid;
        if (fill_valid && (fill_present || neg_cache_en)) begin
            st_d.ent[vic_idx] = '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn,
                                  size: pg_size_e'(fill_size), glob: fill_global,
                                  present: fill_present, perm: fill_perm,
                                  acc: fill_acc, dirty: fill_dirty, cache: fill_cache};
            if (vic_rr) st_d.rr = (st_q.rr == IW'(N - 1)) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // lookup result, same cycle
    always_comb begin
        sel      = st_q.ent[lk_idx];
        om       = off_mask(sel.size);
        lk_hit   = 1'b0;
        lk_fault = 1'b0;
        lk_upd   = 1'b0;
        lk_pa    = '0;
        lk_perm  = '0;
        lk_acc   = 1'b0;
        lk_dirty = 1'b0;
        lk_cache = '0;
        if (lk_valid && lk_any) begin
            lk_fault = !sel.present;
            lk_upd   = sel.present && lk_write && !sel.dirty;
            lk_hit   = sel.present && !(lk_write && !sel.dirty);
            lk_pa    = ({sel.ppn, {PG_SH{1'b0}}} & ~om) |
                       ({{(PA_W - VA_W){1'b0}}, lk_va} & om);
            lk_perm  = sel.perm;
            lk_acc   = sel.acc;
            lk_dirty = sel.dirty;
            lk_cache = sel.cache;
        end
    end

    assert_flush_nonglobal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == INV_NONGLB && !fill_valid) |=> ((valid_q & ~glob_q) == '0));

    assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == INV_ALL && !fill_valid) |=> (valid_q == '0));

    assert_page_removed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == INV_PAGE && !fill_valid) |=> ((valid_q & $past(inv_hitv)) == '0));

    assert_neg_fill_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_present && !neg_cache_en && cmd == INV_NONE)
        |=> (st_q == $past(st_q)));

    assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_fault, lk_upd}));
endmodule

// File: tb/test_tlb_cache.sv
module test_tlb_cache;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        neg_cache_en = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit, lk_fault, lk_upd, lk_acc, lk_dirty;
    logic [39:0] lk_pa;
    logic [2:0]  lk_perm;
    logic [1:0]  lk_cache;
    logic        fill_valid = 1'b0, fill_global = 1'b0, fill_present = 1'b0;
    logic        fill_acc = 1'b0, fill_dirty = 1'b0;
    logic [19:0] fill_vpn = '0, inv_vpn = '0;
    logic [27:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0, fill_cache = '0, inv_cmd = '0;
    logic [2:0]  fill_perm = '0;

    int checks = 0, fails = 0;
    string cur_req = "R11";
    bit checking = 1'b0;

    always #5 clk = ~clk;

    tlb_cache i_tlb_cache (.*);

    // behavioural reference model
    bit     m_v[N], m_g[N], m_p[N], m_a[N], m_d[N];
    longint m_va[N], m_pa[N];
    int     m_sz[N], m_perm[N], m_c[N];
    int     m_rr = 0;

    function automatic int shf(int s);
        return (s == 1) ? 21 : (s == 2) ? 22 : (s == 3) ? 30 : 12;
    endfunction

    function automatic bit covers(int i, longint va);
        return m_v[i] && ((va >> shf(m_sz[i])) == (m_va[i] >> shf(m_sz[i])));
    endfunction

    function automatic int find(longint va);
        for (int i = 0; i < N; i++) if (covers(i, va)) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_rr = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (inv_cmd == 2'd3) m_v[i] = 0;
                if (inv_cmd == 2'd2 && !m_g[i]) m_v[i] = 0;
                if (inv_cmd == 2'd1 && covers(i, longint'(inv_vpn) << 12)) m_v[i] = 0;
            end
            if (fill_valid && (fill_present || neg_cache_en)) begin
                automatic longint fva = longint'(fill_vpn) << 12;
                automatic int k = find(fva);
                if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
                if (k < 0) begin
                    k = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                m_v[k] = 1; m_va[k] = fva; m_pa[k] = longint'(fill_ppn) << 12;
                m_sz[k] = fill_size; m_g[k] = fill_global; m_p[k] = fill_present;
                m_perm[k] = fill_perm; m_a[k] = fill_acc; m_d[k] = fill_dirty;
                m_c[k] = fill_cache;
            end
        end
    end

    task automatic chk(string r, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
        end
    endtask

    // every cycle: compare lookup outputs with the model 2 ns after inputs change
    always begin
        @(negedge clk);
        #2;
        if (checking) begin
            automatic int k = lk_valid ? find(longint'(lk_va)) : -1;
            automatic bit hit = 0, flt = 0, upd = 0;
            automatic longint pa = 0, perm = 0, a = 0, d = 0, c = 0;
            if (k >= 0) begin
                automatic int sh = shf(m_sz[k]);
                flt = !m_p[k];
                upd = m_p[k] && lk_write && !m_d[k];
                hit = m_p[k] && !(lk_write && !m_d[k]);
                pa  = ((m_pa[k] >> sh) << sh) | (longint'(lk_va) & ((64'(1) << sh) - 1));
                perm = m_perm[k]; a = m_a[k]; d = m_d[k]; c = m_c[k];
            end
            chk(cur_req, "hit", lk_hit, hit);
            chk(cur_req, "fault", lk_fault, flt);
            chk(cur_req, "upd", lk_upd, upd);
            chk(cur_req, "pa", lk_pa, pa);
            chk(cur_req, "perm", lk_perm, perm);
            chk(cur_req, "acc", lk_acc, a);
            chk(cur_req, "dirty", lk_dirty, d);
            chk(cur_req, "cache", lk_cache, c);
        end
    end

    task automatic cycle();
        @(negedge clk);
        lk_valid = 0; lk_write = 0; fill_valid = 0; inv_cmd = 0;
    endtask

    task automatic look(longint va, bit wr);
        lk_valid = 1; lk_va = 32'(va); lk_write = wr;
    endtask

    task automatic fill(longint va, longint pa, int sz, bit g, bit p, int perm,
                        bit a, bit d, int c);
        fill_valid = 1; fill_vpn = 20'(va >> 12); fill_ppn = 28'(pa >> 12);
        fill_size = 2'(sz); fill_global = g; fill_present = p;
        fill_perm = 3'(perm); fill_acc = a; fill_dirty = d; fill_cache = 2'(c);
    endtask

    task automatic inv(int cmd, longint va);
        inv_cmd = 2'(cmd); inv_vpn = 20'(va >> 12);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        checking = 1;
        // R11: empty after reset
        cur_req = "R11"; look(32'h0040_3abc, 0); #2;
        chk("R11", "hit after reset", lk_hit, 0);
        cycle();

        // R1 R3: 4 KiB page translation and attributes
        cur_req = "R1"; fill(32'h0040_3000, 40'h12_3456_7000, 0, 0, 1, 5, 1, 0, 2); cycle();
        look(32'h0040_3abc, 0); #2;
        chk("R1", "pa 4K", lk_pa, 40'h12_3456_7abc);
        chk("R3", "perm", lk_perm, 5);
        cycle();
        cur_req = "R8"; look(32'h0040_3abc, 1); #2;
        chk("R8", "upd on clean write", lk_upd, 1);
        cycle();

        // R2: large and huge pages
        cur_req = "R2"; fill(32'h0060_0000, 40'h0A_0040_0000, 1, 1, 1, 7, 1, 1, 0); cycle();
        fill(32'h0C00_0000, 40'h05_0000_0000, 2, 0, 1, 1, 0, 1, 1); cycle();
        fill(32'h4000_0000, 40'h80_4000_0000, 3, 1, 1, 3, 1, 1, 3); cycle();
        look(32'h0077_1234, 0); #2;
        chk("R2", "pa 2M", lk_pa, 40'h0A_0057_1234);
        cycle();
        look(32'h0080_0000, 0); cycle();
        look(32'h0FFF_FFFC, 1); cycle();
        look(32'h7ABC_DEF0, 1); #2;
        chk("R2", "pa 1G", lk_pa, 40'h80_7ABC_DEF0);
        cycle();
        look(32'h8000_0000, 0); cycle();

        // R7: negative caching
        cur_req = "R7"; fill(32'h1000_0000, 0, 0, 0, 0, 0, 0, 0, 0); cycle();
        look(32'h1000_0010, 0); #2;
        chk("R7", "disabled neg fill ignored", lk_fault, 0);
        cycle();
        neg_cache_en = 1;
        fill(32'h1000_0000, 0, 0, 0, 0, 0, 0, 0, 0); cycle();
        look(32'h1000_0010, 0); #2;
        chk("R7", "neg entry faults", lk_fault, 1);
        cycle();
        neg_cache_en = 0;
        look(32'h1000_0010, 1); cycle();

        // R4: address-space switch keeps global slots
        cur_req = "R4"; inv(2, 0); cycle();
        look(32'h0040_3abc, 0); #2;
        chk("R4", "non-global cleared", lk_hit, 0);
        cycle();
        look(32'h0060_0004, 0); #2;
        chk("R4", "global kept", lk_hit, 1);
        cycle();
        look(32'h5000_0000, 0); cycle();

        // R6: single page removes a global slot via an inner address
        cur_req = "R6"; inv(1, 32'h006F_F000); cycle();
        look(32'h0060_0004, 0); #2;
        chk("R6", "global page removed", lk_hit, 0);
        cycle();
        look(32'h5000_0000, 0); cycle();
        inv(0, 32'h4000_0000); cycle();
        look(32'h5000_0000, 0); cycle();

        // R5: everything cleared
        cur_req = "R5"; inv(3, 0); cycle();
        look(32'h5000_0000, 0); #2;
        chk("R5", "global cleared by full flush", lk_hit, 0);
        cycle();

        // R10: same-cycle invalidation and fill
        cur_req = "R10"; fill(32'h0000_5000, 40'h00_0001_1000, 0, 0, 1, 1, 1, 1, 0); cycle();
        inv(3, 0); fill(32'h0000_6000, 40'h00_0002_2000, 0, 1, 1, 1, 1, 1, 0); cycle();
        look(32'h0000_6008, 0); #2;
        chk("R10", "fill survives flush", lk_hit, 1);
        cycle();
        look(32'h0000_5008, 0); cycle();
        inv(1, 32'h0000_6000); fill(32'h0000_6000, 40'h00_0003_3000, 0, 0, 1, 2, 0, 1, 1); cycle();
        look(32'h0000_6008, 0); #2;
        chk("R10", "page inv then refill", lk_pa, 40'h00_0003_3008);
        cycle();

        // R9: replacement order
        cur_req = "R9"; inv(3, 0); cycle();
        for (int i = 0; i < N; i++) begin
            fill(32'h2000_0000 + i * 32'h1000, 40'h30_0000_0000 + i * 40'h1000, 0, 0, 1, 3, 1, 0, 0);
            cycle();
        end
        fill(32'h2001_0000, 40'h31_0000_0000, 0, 0, 1, 3, 1, 1, 0); cycle();
        look(32'h2000_0000, 0); #2;
        chk("R9", "slot 0 evicted", lk_hit, 0);
        cycle();
        look(32'h2000_1000, 0); cycle();
        fill(32'h2002_0000, 40'h32_0000_0000, 0, 0, 1, 3, 1, 1, 0); cycle();
        look(32'h2000_1000, 0); cycle();
        fill(32'h2000_2000, 40'h33_0000_0000, 0, 0, 1, 7, 1, 1, 1); cycle();
        look(32'h2000_2040, 1); #2;
        chk("R9", "overwrite in place", lk_pa, 40'h33_0000_0040);
        cycle();
        look(32'h2000_3000, 0); cycle();
        look(32'h2001_0000, 1); cycle();

        checking = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule